// File: doc/BRIEF.md
# Debug Register Scan Chain

This block is the data-register side of a debug scan path that lives behind a JTAG TAP controller. While the TAP is in Shift-DR, the block offers a 38-bit shift register. The host shifts a 32-bit data field into it, then a 5-bit register address, then a direction flag. When Update-DR arrives, the block acts on that word. A write stores the data field into the addressed debug register. A read copies the addressed register into a read-back latch, and the next Capture-DR loads that latch into the shift register so the host can shift it out.

The register bank holds two watchpoint units. Each unit has six 32-bit registers: an address value, an address mask, a data value, a data mask, a control value and a control mask. Every register drives an output bus towards the watchpoint comparators, which are not part of this block. The block also reports an enable flag for each unit, taken from bit 8 of that unit's control value.

The TAP controller supplies single-cycle Capture, Shift and Update strobes on TCK. It also supplies a select for this chain and a flag that says the current instruction allows test access.

Top module: `dbg_regchain`

## Requirements
- R1: The chain is 38 bits long. Bits 31:0 hold the data field, bits 36:32 the address and bit 37 the direction flag. Each shift moves the chain one place towards bit 0: `tdi` enters bit 37 and `tdo` shows bit 0. Data and address therefore travel least significant bit first, and the flag is the last bit shifted in. A word shifted in comes out unchanged 38 shifts later.
- R2: On a selected Capture-DR, the data field loads the read-back latch and bits 37:32 load zero.
- R3: On a selected and enabled Update-DR with the flag at 1, the data field is written into the addressed register. The new value is visible on the outputs after that edge.
- R4: On a selected and enabled Update-DR with the flag at 0, the addressed register is copied into the read-back latch, and no register changes. The value appears in the data field of the next scan.
- R5: Watchpoint unit n, register k sits at address 8n+k. The register order k is: 0 address value, 1 address mask, 2 data value, 3 data mask, 4 control value, 5 control mask.
- R6: A write to an unimplemented address (slot 6 or 7 of a unit, or a unit number of 2 or more) changes nothing. A read from such an address loads zero into the read-back latch.
- R7: Capture, Shift and Update have no effect while `chain_sel` is low. An Update with `test_en` low changes no register.
- R8: `wp_enable[n]` equals bit 8 of unit n's control value. Writing 0x100 sets it and writing 0 clears it.
- R9: While reset is asserted, all registers, the read-back latch and the chain are zero, and `tdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | TCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| chain_sel | input | 1 | This chain is the selected data register |
| test_en | input | 1 | Active instruction permits register access |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| update_dr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0) |
| wp_addr_val | output | 64 | Address values, unit n at bits 32n+31:32n |
| wp_addr_msk | output | 64 | Address masks |
| wp_data_val | output | 64 | Data values |
| wp_data_msk | output | 64 | Data masks |
| wp_ctrl_val | output | 64 | Control values |
| wp_ctrl_msk | output | 64 | Control masks |
| wp_enable | output | 2 | Per-unit enable (control value bit 8) |

## Verification
Register outputs change on the Update edge itself, so the bench reads them at the falling edge right after the Update cycle. The read-back latch also loads on Update, but a read result only appears on `tdo` after the next Capture edge. The bench therefore runs a second full scan and takes the data bits from that scan. Inputs are driven and `tdo` is sampled at falling edges: bit i of a scan is taken after i shift edges. This lines up with the single chain register between `tdi` and `tdo`.

// File: rtl/dbg_regchain_pkg.sv
package dbg_regchain_pkg;
  // register slots inside one watchpoint unit
  localparam int unsigned WPF_ADDR_VAL = 0;
  localparam int unsigned WPF_ADDR_MSK = 1;
  localparam int unsigned WPF_DATA_VAL = 2;
  localparam int unsigned WPF_DATA_MSK = 3;
  localparam int unsigned WPF_CTRL_VAL = 4;
  localparam int unsigned WPF_CTRL_MSK = 5;
  localparam int unsigned WP_FIELDS    = 6;
endpackage

// File: rtl/dbg_chain_sr.sv
module dbg_chain_sr #(
  parameter int unsigned CHAIN_W = 38,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_en,
  input  logic               shift_en,
  input  logic               tdi,
  input  logic [DATA_W-1:0]  cap_data,
  output logic [CHAIN_W-1:0] sr_q
);
  localparam int unsigned PAD_W = CHAIN_W - DATA_W;

  logic [CHAIN_W-1:0] sr_d;
  logic               sr_ce;

  always_comb begin
    sr_ce = cap_en | shift_en;
    sr_d  = sr_q;
    if (cap_en) begin
      sr_d = {{PAD_W{1'b0}}, cap_data};
    end else if (shift_en) begin
      sr_d = {tdi, sr_q[CHAIN_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (sr_ce) begin
      sr_q <= sr_d;
    end
  end
endmodule

// File: rtl/dbg_wp_unit.sv
module dbg_wp_unit
  import dbg_regchain_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SLOT_W = 3,
  parameter int unsigned EN_BIT = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [SLOT_W-1:0]                  wr_slot,
  input  logic [DATA_W-1:0]                  wr_data,
  input  logic [SLOT_W-1:0]                  rd_slot,
  output logic [DATA_W-1:0]                  rd_data,
  output logic [WP_FIELDS-1:0][DATA_W-1:0]   fields_q,
  output logic                               wp_en
);
  logic [WP_FIELDS-1:0][DATA_W-1:0] fields_d;

  always_comb begin
    fields_d = fields_q;
    for (int k = 0; k < WP_FIELDS; k++) begin
      if (wr_en && (wr_slot == SLOT_W'(k))) begin
        fields_d[k] = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields_q <= '0;
    end else if (wr_en) begin
      fields_q <= fields_d;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < WP_FIELDS; k++) begin
      if (rd_slot == SLOT_W'(k)) begin
        rd_data = fields_q[k];
      end
    end
  end

  assign wp_en = fields_q[WPF_CTRL_VAL][EN_BIT];
endmodule

// File: rtl/dbg_reg_bank.sv
module dbg_reg_bank
  import dbg_regchain_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned SLOT_W = 3,
  parameter int unsigned NUM_WP = 2,
  parameter int unsigned EN_BIT = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd_wr,
  input  logic                     upd_rd,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdback_q,
  output logic [NUM_WP*DATA_W-1:0] addr_val,
  output logic [NUM_WP*DATA_W-1:0] addr_msk,
  output logic [NUM_WP*DATA_W-1:0] data_val,
  output logic [NUM_WP*DATA_W-1:0] data_msk,
  output logic [NUM_WP*DATA_W-1:0] ctrl_val,
  output logic [NUM_WP*DATA_W-1:0] ctrl_msk,
  output logic [NUM_WP-1:0]        enable
);
  localparam int unsigned UNIT_W = ADDR_W - SLOT_W;

  logic [UNIT_W-1:0] unit;
  logic [SLOT_W-1:0] slot;
  logic              unit_ok;
  logic              slot_ok;
  logic              addr_ok;

  assign unit    = addr[ADDR_W-1:SLOT_W];
  assign slot    = addr[SLOT_W-1:0];
  assign unit_ok = ({1'b0, unit} < (UNIT_W+1)'(NUM_WP));
  assign slot_ok = (slot < SLOT_W'(WP_FIELDS));
  assign addr_ok = unit_ok & slot_ok;

  logic [DATA_W-1:0]                unit_rd     [NUM_WP];
  logic [WP_FIELDS-1:0][DATA_W-1:0] unit_fields [NUM_WP];

  for (genvar u = 0; u < NUM_WP; u++) begin : g_unit
    logic unit_wr;
    assign unit_wr = upd_wr & addr_ok & (unit == UNIT_W'(u));

    dbg_wp_unit #(
      .DATA_W (DATA_W),
      .SLOT_W (SLOT_W),
      .EN_BIT (EN_BIT)
    ) u_wp (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (unit_wr),
      .wr_slot  (slot),
      .wr_data  (wdata),
      .rd_slot  (slot),
      .rd_data  (unit_rd[u]),
      .fields_q (unit_fields[u]),
      .wp_en    (enable[u])
    );

    assign addr_val[u*DATA_W +: DATA_W] = unit_fields[u][WPF_ADDR_VAL];
    assign addr_msk[u*DATA_W +: DATA_W] = unit_fields[u][WPF_ADDR_MSK];
    assign data_val[u*DATA_W +: DATA_W] = unit_fields[u][WPF_DATA_VAL];
    assign data_msk[u*DATA_W +: DATA_W] = unit_fields[u][WPF_DATA_MSK];
    assign ctrl_val[u*DATA_W +: DATA_W] = unit_fields[u][WPF_CTRL_VAL];
    assign ctrl_msk[u*DATA_W +: DATA_W] = unit_fields[u][WPF_CTRL_MSK];
  end

  logic [DATA_W-1:0] sel_rd;
  logic [DATA_W-1:0] rdback_d;

  always_comb begin
    sel_rd = '0;
    for (int u = 0; u < NUM_WP; u++) begin
      if (unit == UNIT_W'(u)) begin
        sel_rd = unit_rd[u];
      end
    end
  end

  always_comb begin
    rdback_d = addr_ok ? sel_rd : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdback_q <= '0;
    end else if (upd_rd) begin
      rdback_q <= rdback_d;
    end
  end
endmodule

// File: rtl/dbg_regchain.sv
module dbg_regchain #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned NUM_WP    = 2,
  parameter int unsigned WP_STRIDE = 8,
  parameter int unsigned EN_BIT    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     chain_sel,
  input  logic                     test_en,
  input  logic                     capture_dr,
  input  logic                     shift_dr,
  input  logic                     update_dr,
  input  logic                     tdi,
  output logic                     tdo,
  output logic [NUM_WP*DATA_W-1:0] wp_addr_val,
  output logic [NUM_WP*DATA_W-1:0] wp_addr_msk,
  output logic [NUM_WP*DATA_W-1:0] wp_data_val,
  output logic [NUM_WP*DATA_W-1:0] wp_data_msk,
  output logic [NUM_WP*DATA_W-1:0] wp_ctrl_val,
  output logic [NUM_WP*DATA_W-1:0] wp_ctrl_msk,
  output logic [NUM_WP-1:0]        wp_enable
);
  localparam int unsigned CHAIN_W = DATA_W + ADDR_W + 1;
  localparam int unsigned SLOT_W  = $clog2(WP_STRIDE);

  // asynchronous assert, synchronous release
  logic rst_meta;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic               cap_en;
  logic               shift_en;
  logic               upd_en;
  logic               upd_wr;
  logic               upd_rd;
  logic [CHAIN_W-1:0] chain_q;
  logic [DATA_W-1:0]  rdback_q;
  logic [DATA_W-1:0]  fld_data;
  logic [ADDR_W-1:0]  fld_addr;
  logic               fld_rw;

  assign cap_en   = chain_sel & capture_dr;
  assign shift_en = chain_sel & shift_dr & ~capture_dr;
  assign upd_en   = chain_sel & test_en & update_dr;

  assign fld_data = chain_q[DATA_W-1:0];
  assign fld_addr = chain_q[DATA_W +: ADDR_W];
  assign fld_rw   = chain_q[CHAIN_W-1];

  assign upd_wr = upd_en &  fld_rw;
  assign upd_rd = upd_en & ~fld_rw;

  dbg_chain_sr #(
    .CHAIN_W (CHAIN_W),
    .DATA_W  (DATA_W)
  ) u_sr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cap_en   (cap_en),
    .shift_en (shift_en),
    .tdi      (tdi),
    .cap_data (rdback_q),
    .sr_q     (chain_q)
  );

  dbg_reg_bank #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .SLOT_W (SLOT_W),
    .NUM_WP (NUM_WP),
    .EN_BIT (EN_BIT)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .upd_wr   (upd_wr),
    .upd_rd   (upd_rd),
    .addr     (fld_addr),
    .wdata    (fld_data),
    .rdback_q (rdback_q),
    .addr_val (wp_addr_val),
    .addr_msk (wp_addr_msk),
    .data_val (wp_data_val),
    .data_msk (wp_data_msk),
    .ctrl_val (wp_ctrl_val),
    .ctrl_msk (wp_ctrl_msk),
    .enable   (wp_enable)
  );

  assign tdo = chain_q[0];
endmodule

// File: rtl/dbg_regchain_chk.sv
module dbg_regchain_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned NUM_WP  = 2,
  parameter int unsigned SLOT_W  = 3,
  parameter int unsigned CHAIN_W = 38,
  parameter int unsigned EN_BIT  = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     chain_sel,
  input logic                     test_en,
  input logic                     capture_dr,
  input logic                     shift_dr,
  input logic                     update_dr,
  input logic                     tdi,
  input logic [CHAIN_W-1:0]       chain_q,
  input logic [DATA_W-1:0]        rdback_q,
  input logic [NUM_WP*DATA_W-1:0] wp_addr_val,
  input logic [NUM_WP*DATA_W-1:0] wp_addr_msk,
  input logic [NUM_WP*DATA_W-1:0] wp_data_val,
  input logic [NUM_WP*DATA_W-1:0] wp_data_msk,
  input logic [NUM_WP*DATA_W-1:0] wp_ctrl_val,
  input logic [NUM_WP*DATA_W-1:0] wp_ctrl_msk,
  input logic [NUM_WP-1:0]        wp_enable
);
  localparam int unsigned UNIT_W = ADDR_W - SLOT_W;

  logic [NUM_WP*DATA_W*6-1:0] all_regs;
  logic [ADDR_W-1:0]          c_addr;
  logic                       c_rw;
  logic                       c_mapped;
  logic                       upd;

  assign all_regs = {wp_addr_val, wp_addr_msk, wp_data_val,
                     wp_data_msk, wp_ctrl_val, wp_ctrl_msk};
  assign c_addr   = chain_q[DATA_W +: ADDR_W];
  assign c_rw     = chain_q[CHAIN_W-1];
  assign c_mapped = ({1'b0, c_addr[ADDR_W-1:SLOT_W]} < (UNIT_W+1)'(NUM_WP)) &&
                    (c_addr[SLOT_W-1:0] < SLOT_W'(6));
  assign upd      = chain_sel && test_en && update_dr;

  AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_sel && shift_dr && !capture_dr) |=>
      (chain_q == {$past(tdi), $past(chain_q[CHAIN_W-1:1])})); // R1

  AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_sel && capture_dr) |=>
      (chain_q == {{(CHAIN_W-DATA_W){1'b0}}, $past(rdback_q)})); // R2

  AST_READ_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !c_rw) |=> $stable(all_regs)); // R4

  AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && c_rw && !c_mapped) |=> $stable(all_regs)); // R6

  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !c_rw && !c_mapped) |=> (rdback_q == '0)); // R6

  AST_NO_ACCESS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(all_regs)); // R7

  AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && c_rw && (c_addr == ADDR_W'(4))) |=>
      (wp_enable[0] == $past(chain_q[EN_BIT]))); // R8
endmodule

bind dbg_regchain dbg_regchain_chk #(
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .NUM_WP  (NUM_WP),
  .SLOT_W  (SLOT_W),
  .CHAIN_W (CHAIN_W),
  .EN_BIT  (EN_BIT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .chain_sel   (chain_sel),
  .test_en     (test_en),
  .capture_dr  (capture_dr),
  .shift_dr    (shift_dr),
  .update_dr   (update_dr),
  .tdi         (tdi),
  .chain_q     (chain_q),
  .rdback_q    (rdback_q),
  .wp_addr_val (wp_addr_val),
  .wp_addr_msk (wp_addr_msk),
  .wp_data_val (wp_data_val),
  .wp_data_msk (wp_data_msk),
  .wp_ctrl_val (wp_ctrl_val),
  .wp_ctrl_msk (wp_ctrl_msk),
  .wp_enable   (wp_enable)
);

// File: tb/sim_dbg_regchain.sv
`timescale 1ns/1ps
module sim_dbg_regchain;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        chain_sel, test_en, capture_dr, shift_dr, update_dr, tdi;
  logic        tdo;
  logic [63:0] wp_addr_val, wp_addr_msk, wp_data_val, wp_data_msk, wp_ctrl_val, wp_ctrl_msk;
  logic [1:0]  wp_enable;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [2][6];

  always #2 clk = ~clk;

  dbg_regchain u0 (
    .clk(clk), .rst_n(rst_n), .chain_sel(chain_sel), .test_en(test_en),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .tdo(tdo),
    .wp_addr_val(wp_addr_val), .wp_addr_msk(wp_addr_msk),
    .wp_data_val(wp_data_val), .wp_data_msk(wp_data_msk),
    .wp_ctrl_val(wp_ctrl_val), .wp_ctrl_msk(wp_ctrl_msk),
    .wp_enable(wp_enable)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pack_field(input int f);
    return {model[1][f], model[0][f]};
  endfunction

  task automatic chk_outputs(input string req);
    chk({req, " addr_val"}, wp_addr_val, pack_field(0));
    chk({req, " addr_msk"}, wp_addr_msk, pack_field(1));
    chk({req, " data_val"}, wp_data_val, pack_field(2));
    chk({req, " data_msk"}, wp_data_msk, pack_field(3));
    chk({req, " ctrl_val"}, wp_ctrl_val, pack_field(4));
    chk({req, " ctrl_msk"}, wp_ctrl_msk, pack_field(5));
    chk({req, " enable"}, {62'd0, wp_enable}, {62'd0, model[1][4][8], model[0][4][8]});
  endtask

  // one full capture / shift 38 / optional update pass
  task automatic scan(input logic rw, input logic [4:0] addr, input logic [31:0] data,
                      input logic do_upd, output logic [37:0] got);
    logic [37:0] word;
    word = {rw, addr, data};
    @(negedge clk) capture_dr = 1'b1;
    @(negedge clk) capture_dr = 1'b0; shift_dr = 1'b1;
    for (int i = 0; i < 38; i++) begin
      tdi    = word[i];
      got[i] = tdo;
      @(negedge clk);
    end
    shift_dr  = 1'b0;
    update_dr = do_upd;
    @(negedge clk) update_dr = 1'b0;
  endtask

  task automatic write_reg(input logic [4:0] addr, input logic [31:0] data);
    logic [37:0] g;
    scan(1'b1, addr, data, 1'b1, g);
    if (addr[4:3] < 2 && addr[2:0] < 6) model[addr[3]][addr[2:0]] = data;
  endtask

  task automatic read_reg(input logic [4:0] addr, output logic [31:0] val);
    logic [37:0] g;
    scan(1'b0, addr, 32'd0, 1'b1, g);
    scan(1'b0, 5'd31, 32'd0, 1'b1, g);
    chk("R2 capture pads zero", {58'd0, g[37:32]}, 64'd0);
    val = g[31:0];
  endtask

  task automatic test_reset();
    chk("R9 tdo in reset", {63'd0, tdo}, 64'd0);
    chk_outputs("R9 reset");
  endtask

  task automatic test_write_map();
    for (int u = 0; u < 2; u++)
      for (int k = 0; k < 6; k++)
        write_reg(5'(u*8 + k), 32'hC0DE_0000 ^ 32'(u << 12) ^ 32'(k << 4) ^ 32'h1);
    chk_outputs("R3 R5 write all slots");
  endtask

  task automatic test_read_back();
    logic [31:0] v;
    for (int u = 0; u < 2; u++)
      for (int k = 0; k < 6; k++) begin
        read_reg(5'(u*8 + k), v);
        chk("R4 R5 read back", {32'd0, v}, {32'd0, model[u][k]});
      end
    chk_outputs("R4 reads leave registers");
  endtask

  task automatic test_order();
    logic [37:0] g1, g2;
    logic [37:0] pat;
    write_reg(5'd9, 32'h8000_0001);
    chk_outputs("R1 field order write");
    pat = 38'h2A_5A5A_C3C3;
    @(negedge clk) capture_dr = 1'b1;
    @(negedge clk) capture_dr = 1'b0; shift_dr = 1'b1;
    for (int i = 0; i < 76; i++) begin
      tdi = (i < 38) ? pat[i] : 1'b0;
      if (i >= 38) g2[i-38] = tdo; else g1[i] = tdo;
      @(negedge clk);
    end
    shift_dr = 1'b0;
    chk("R1 pass-through after 38 shifts", {26'd0, g2}, {26'd0, pat});
    chk_outputs("R1 no update no change");
  endtask

  task automatic test_unmapped();
    logic [31:0] v;
    write_reg(5'd6, 32'hDEAD_0006);
    write_reg(5'd15, 32'hDEAD_000F);
    write_reg(5'd16, 32'hDEAD_0010);
    write_reg(5'd31, 32'hDEAD_001F);
    chk_outputs("R6 unmapped writes ignored");
    read_reg(5'd1, v);
    read_reg(5'd7, v);
    chk("R6 unmapped read zero", {32'd0, v}, 64'd0);
    read_reg(5'd20, v);
    chk("R6 unit 2 read zero", {32'd0, v}, 64'd0);
  endtask

  task automatic test_gating();
    logic [37:0] g;
    logic [31:0] v;
    test_en = 1'b0;
    scan(1'b1, 5'd2, 32'h1234_5678, 1'b1, g);
    test_en = 1'b1;
    chk_outputs("R7 test_en low blocks write");
    chain_sel = 1'b0;
    scan(1'b1, 5'd10, 32'h8765_4321, 1'b1, g);
    chain_sel = 1'b1;
    chk_outputs("R7 chain_sel low blocks write");
    read_reg(5'd10, v);
    chk("R7 register kept", {32'd0, v}, {32'd0, model[1][2]});
  endtask

  task automatic test_enable();
    write_reg(5'd12, 32'h0000_0100);
    chk("R8 unit1 enabled", {62'd0, wp_enable}, {62'd0, 1'b1, model[0][4][8]});
    write_reg(5'd4, 32'h0000_0100);
    write_reg(5'd5, 32'hFFFF_FFF7);
    chk("R8 both enabled", {62'd0, wp_enable}, 64'd3);
    write_reg(5'd12, 32'h0);
    chk("R8 unit1 disabled", {62'd0, wp_enable}, 64'd1);
    chk_outputs("R8 outputs");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int u = 0; u < 2; u++) for (int k = 0; k < 6; k++) model[u][k] = '0;
    rst_n = 1'b0; chain_sel = 1'b1; test_en = 1'b1;
    capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0; tdi = 1'b0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_write_map();
    test_read_back();
    test_order();
    test_unmapped();
    test_gating();
    test_enable();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule